// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This unit reports, in hertz, the frequency that one of several derived clocks would run at, given the present select and divider fields of the clock control registers. It generates no clock. A fixed 24 MHz crystal feeds two phase-locked loops. The system loop multiplies by 22 or by 20, and the USB loop always multiplies by 20. Two fractional dividers scale the system loop by 18/frac. A chain of muxes and divide-by-(1+n) stages then produces the root, bus, IPG and peripheral frequencies.

A requester puts a clock identifier and the field values on the inputs and pulses `req_i`. The unit captures everything on the accepting edge. It walks the chain with one shared iterative integer divider and all arithmetic held at 64 bits. It then pulses `done_o` once, with the low 32 bits of the result on `freq_o` and a flag on `err_o` for cases it cannot evaluate. Simple identifiers finish one cycle after they are accepted. The longest path takes a few hundred cycles.

Top module: `clkfreq_eval`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `busy_o` and `err_o` are 0 and `freq_o` is 0.
- R2: Identifier codes 0 (none), 3 (low-frequency), 4 (crystal) and 5 (crystal/8) return 0, 32768, 24000000 and 3000000 with `err_o`=0, and `done_o` rises in the cycle right after the accepting edge.
- R3: With `root_sel_i`=0 and `pre_sel_i`=0, the root source is 24 MHz x 22 when `sys_mul22_i`=1 and 24 MHz x 20 when it is 0.
- R4: `pre_sel_i` codes 1, 2 and 3 select the system loop x 18 / `pfd2_frac_i`, the system loop x 18 / `pfd0_frac_i`, and the `pfd2_frac_i` result halved.
- R5: With `root_sel_i`=1, the root is the alternate mux divided by (1+`alt_podf_i`). `alt_sel_i` code 0 selects 480000000, code 1 selects 24000000, and codes 2 and 3 give 0 with no error.
- R6: Identifier code 1 (IPG) returns the root divided by (1+`bus_podf_i`) and then by (1+`ipg_podf_i`).
- R7: Identifier code 2 (peripheral) takes the IPG value when `per_sel_i`=0 or 24000000 when it is 1, then divides it by (1+`per_podf_i`).
- R8: A zero frac field on the fractional divider that the selected path uses gives 0 with `err_o`=1. A zero frac on the unused divider has no effect.
- R9: Identifier codes 6 and 7 return 0 with `err_o`=1.
- R10: Each division truncates toward zero on the 64-bit value. `freq_o` carries the low 32 bits of the final 64-bit value.
- R11: `busy_o` is 1 from the accepting edge until `done_o`, and `done_o` is high for exactly one cycle per accepted request.
- R12: Field values and requests that arrive while `busy_o`=1 do not change the result of the request in flight.
- R13: `freq_o` and `err_o` keep their last result until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start an evaluation; honoured only while idle |
| clk_id_i | input | 3 | Clock identifier (0 none, 1 IPG, 2 peripheral, 3 low-freq, 4 crystal, 5 crystal/8) |
| sys_mul22_i | input | 1 | System loop multiplier select (1: x22, 0: x20) |
| pfd0_frac_i | input | 6 | Frac field of fractional divider 0 |
| pfd2_frac_i | input | 6 | Frac field of fractional divider 2 |
| pre_sel_i | input | 2 | Pre-root mux select |
| alt_sel_i | input | 2 | Alternate root mux select |
| alt_podf_i | input | 3 | Alternate root divider field |
| root_sel_i | input | 1 | Root select (0 pre-root path, 1 alternate path) |
| bus_podf_i | input | 3 | Bus divider field |
| ipg_podf_i | input | 2 | IPG divider field |
| per_sel_i | input | 1 | Peripheral source select (0 IPG, 1 crystal) |
| per_podf_i | input | 6 | Peripheral divider field |
| busy_o | output | 1 | Request accepted and not yet finished |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last result could not be evaluated |
| freq_o | output | 32 | Last result in Hz |

## Verification
The assertions assume that the requester changes `req_i` and the field inputs only away from the rising edge, and that these inputs are never unknown at an edge. They also assume that a request seen while busy is dropped and not queued. The bench drives every input on the falling edge and holds the fields steady across the accepting edge. It changes fields and pulses `req_i` mid-flight only on purpose, to show that such activity is ignored. Random field values span each field's full range, so zero frac fields and the reserved alternate selects come up on their own, next to directed cases at each mux code.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;
  localparam int unsigned OSC_HZ   = 24_000_000;
  localparam int unsigned LOWF_HZ  = 32_768;
  localparam int unsigned USB_MUL  = 20;
  localparam int unsigned SYS_MULH = 22;
  localparam int unsigned SYS_MULL = 20;
  localparam int unsigned PFD_NUM  = 18;
  localparam int unsigned XTAL_DIV = 8;

  localparam int ACC_W      = 64;
  localparam int RES_W      = 32;
  localparam int ID_W       = 3;
  localparam int FRAC_W     = 6;
  localparam int SEL_W      = 2;
  localparam int ALT_PODF_W = 3;
  localparam int BUS_PODF_W = 3;
  localparam int IPG_PODF_W = 2;
  localparam int PER_PODF_W = 6;
  localparam int DVS_W      = 8;

  typedef enum logic [ID_W-1:0] {
    CID_NONE   = 3'd0,
    CID_IPG    = 3'd1,
    CID_PERIPH = 3'd2,
    CID_LOWF   = 3'd3,
    CID_XTAL   = 3'd4,
    CID_XTAL8  = 3'd5
  } clk_id_e;

  typedef struct packed {
    logic [ID_W-1:0]       id;
    logic                  mul22;
    logic [FRAC_W-1:0]     pfd0_frac;
    logic [FRAC_W-1:0]     pfd2_frac;
    logic [SEL_W-1:0]      pre_sel;
    logic [SEL_W-1:0]      alt_sel;
    logic [ALT_PODF_W-1:0] alt_podf;
    logic                  root_sel;
    logic [BUS_PODF_W-1:0] bus_podf;
    logic [IPG_PODF_W-1:0] ipg_podf;
    logic                  per_sel;
    logic [PER_PODF_W-1:0] per_podf;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PFD, ST_HALF, ST_ALT, ST_BUS, ST_IPG, ST_PER, ST_DONE
  } step_e;
endpackage

// File: rtl/clkfreq_src.sv
module clkfreq_src
  import clkfreq_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  cfg_t              cfg_i,
  output logic [W-1:0]      pll_sys_o,
  output logic [W-1:0]      alt_base_o,
  output logic [W-1:0]      pfd_scaled_o,
  output logic [FRAC_W-1:0] pfd_frac_o,
  output logic              pfd_frac_zero_o
);
  logic [W-1:0] osc_w;
  logic [W-1:0] pll_usb_w;

  always_comb begin
    osc_w        = W'(OSC_HZ);
    pll_usb_w    = osc_w * W'(USB_MUL);
    pll_sys_o    = osc_w * (cfg_i.mul22 ? W'(SYS_MULH) : W'(SYS_MULL));
    pfd_scaled_o = pll_sys_o * W'(PFD_NUM);
    // code 2 uses divider 0; codes 1 and 3 use divider 2
    pfd_frac_o      = (cfg_i.pre_sel == 2'd2) ? cfg_i.pfd0_frac : cfg_i.pfd2_frac;
    pfd_frac_zero_o = (pfd_frac_o == '0);
    unique case (cfg_i.alt_sel)
      2'd0:    alt_base_o = pll_usb_w;
      2'd1:    alt_base_o = osc_w;
      default: alt_base_o = '0;  // bypass source and reserved code read as 0 Hz
    endcase
  end
endmodule

// File: rtl/clkfreq_div.sv
module clkfreq_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DVS_W:0]   trial;
  logic             fits;

  always_comb begin
    trial  = {rem_q, quo_q[DVD_W-1]};
    fits   = (trial >= {1'b0, dvs_q});
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i && !busy_q) begin
      quo_d  = dividend_i;
      rem_d  = '0;
      dvs_d  = divisor_i;
      cnt_d  = CNT_W'(DVD_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? DVS_W'(trial - {1'b0, dvs_q}) : trial[DVS_W-1:0];
      quo_d = {quo_q[DVD_W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // R8
  nonzero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |-> (divisor_i != '0));
  // R10
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < dvs_q));
  // R11
  div_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/clkfreq_eval.sv
module clkfreq_eval
  import clkfreq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [ID_W-1:0]       clk_id_i,
  input  logic                  sys_mul22_i,
  input  logic [FRAC_W-1:0]     pfd0_frac_i,
  input  logic [FRAC_W-1:0]     pfd2_frac_i,
  input  logic [SEL_W-1:0]      pre_sel_i,
  input  logic [SEL_W-1:0]      alt_sel_i,
  input  logic [ALT_PODF_W-1:0] alt_podf_i,
  input  logic                  root_sel_i,
  input  logic [BUS_PODF_W-1:0] bus_podf_i,
  input  logic [IPG_PODF_W-1:0] ipg_podf_i,
  input  logic                  per_sel_i,
  input  logic [PER_PODF_W-1:0] per_podf_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [RES_W-1:0]      freq_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  cfg_t             cfg_in, cfg_q, cfg_sel;
  step_e            state_q, state_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             err_q, err_d;
  logic             launched_q, launched_d;
  logic             accept;
  logic             div_start, div_busy, div_done;
  logic [DVS_W-1:0] divisor;
  logic [ACC_W-1:0] div_quot;
  logic [ACC_W-1:0] pll_sys, alt_base, pfd_scaled;
  logic [FRAC_W-1:0] pfd_frac;
  logic             pfd_frac_zero;
  step_e            step_after;

  always_comb begin
    cfg_in = '{id: clk_id_i, mul22: sys_mul22_i, pfd0_frac: pfd0_frac_i,
               pfd2_frac: pfd2_frac_i, pre_sel: pre_sel_i, alt_sel: alt_sel_i,
               alt_podf: alt_podf_i, root_sel: root_sel_i, bus_podf: bus_podf_i,
               ipg_podf: ipg_podf_i, per_sel: per_sel_i, per_podf: per_podf_i};
  end

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign cfg_sel = accept ? cfg_in : cfg_q;

  clkfreq_src #(.W(ACC_W)) src_i (
    .cfg_i           (cfg_sel),
    .pll_sys_o       (pll_sys),
    .alt_base_o      (alt_base),
    .pfd_scaled_o    (pfd_scaled),
    .pfd_frac_o      (pfd_frac),
    .pfd_frac_zero_o (pfd_frac_zero)
  );

  clkfreq_div #(.DVD_W(ACC_W), .DVS_W(DVS_W)) div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (div_start),
    .dividend_i (acc_q),
    .divisor_i  (divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // divisor and successor step of each division step
  always_comb begin
    divisor    = DVS_W'(1);
    step_after = ST_DONE;
    unique case (state_q)
      ST_PFD: begin
        divisor    = DVS_W'(pfd_frac);
        step_after = (cfg_q.pre_sel == 2'd3) ? ST_HALF : ST_BUS;
      end
      ST_HALF: begin
        divisor    = DVS_W'(2);
        step_after = ST_BUS;
      end
      ST_ALT: begin
        divisor    = DVS_W'(cfg_q.alt_podf) + DVS_W'(1);
        step_after = ST_BUS;
      end
      ST_BUS: begin
        divisor    = DVS_W'(cfg_q.bus_podf) + DVS_W'(1);
        step_after = ST_IPG;
      end
      ST_IPG: begin
        divisor    = DVS_W'(cfg_q.ipg_podf) + DVS_W'(1);
        step_after = (cfg_q.id == CID_PERIPH) ? ST_PER : ST_DONE;
      end
      ST_PER: begin
        divisor    = DVS_W'(cfg_q.per_podf) + DVS_W'(1);
        step_after = ST_DONE;
      end
      default: ;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    acc_d      = acc_q;
    err_d      = err_q;
    launched_d = launched_q;
    div_start  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          err_d      = 1'b0;
          launched_d = 1'b0;
          state_d    = ST_DONE;
          unique case (cfg_in.id)
            CID_NONE:  acc_d = '0;
            CID_LOWF:  acc_d = ACC_W'(LOWF_HZ);
            CID_XTAL:  acc_d = ACC_W'(OSC_HZ);
            CID_XTAL8: acc_d = ACC_W'(OSC_HZ / XTAL_DIV);
            CID_IPG, CID_PERIPH: begin
              if (cfg_in.id == CID_PERIPH && cfg_in.per_sel) begin
                acc_d   = ACC_W'(OSC_HZ);
                state_d = ST_PER;
              end else if (cfg_in.root_sel) begin
                acc_d   = alt_base;
                state_d = ST_ALT;
              end else if (cfg_in.pre_sel == 2'd0) begin
                acc_d   = pll_sys;
                state_d = ST_BUS;
              end else if (pfd_frac_zero) begin
                acc_d = '0;
                err_d = 1'b1;
              end else begin
                acc_d   = pfd_scaled;
                state_d = ST_PFD;
              end
            end
            default: begin
              acc_d = '0;
              err_d = 1'b1;
            end
          endcase
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: begin
        if (!launched_q && !div_busy) begin
          div_start  = 1'b1;
          launched_d = 1'b1;
        end else if (div_done) begin
          acc_d      = div_quot;
          launched_d = 1'b0;
          state_d    = step_after;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      acc_q      <= '0;
      err_q      <= 1'b0;
      launched_q <= 1'b0;
      cfg_q      <= '0;
    end else begin
      state_q    <= state_d;
      acc_q      <= acc_d;
      err_q      <= err_d;
      launched_q <= launched_d;
      if (accept) cfg_q <= cfg_in;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;
  assign freq_o = acc_q[RES_W-1:0];

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  bad_id_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && req_i && clk_id_i > ID_W'(5)) |=> (done_o && err_o && freq_o == '0));
  // R8
  frac_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && req_i && clk_id_i == ID_W'(1) && !root_sel_i && pre_sel_i != 2'd0 &&
     ((pre_sel_i == 2'd2) ? (pfd0_frac_i == '0) : (pfd2_frac_i == '0)))
    |=> (done_o && err_o && freq_o == '0));
  // R13
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !req_i) |=> ($stable(freq_o) && $stable(err_o)));
  // R2
  const_id_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && req_i && clk_id_i == ID_W'(4)) |=> (done_o && freq_o == RES_W'(OSC_HZ)));
endmodule

// File: tb/clkfreq_eval_tb_top.sv
module clkfreq_eval_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [2:0] s_id;
  logic s_ds;
  logic [5:0] s_f0, s_f2;
  logic [1:0] s_pre, s_c2s;
  logic [2:0] s_c2p;
  logic s_psel;
  logic [2:0] s_ahb;
  logic [1:0] s_ipg;
  logic s_persel;
  logic [5:0] s_perp;
  logic busy_o, done_o, err_o;
  logic [31:0] freq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clkfreq_eval dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clk_id_i(s_id),
    .sys_mul22_i(s_ds), .pfd0_frac_i(s_f0), .pfd2_frac_i(s_f2),
    .pre_sel_i(s_pre), .alt_sel_i(s_c2s), .alt_podf_i(s_c2p),
    .root_sel_i(s_psel), .bus_podf_i(s_ahb), .ipg_podf_i(s_ipg),
    .per_sel_i(s_persel), .per_podf_i(s_perp),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .freq_o(freq_o)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [2:0] id);
    logic [63:0] v, sysp;
    logic e;
    e = 1'b0; v = '0;
    sysp = 64'd24000000 * (s_ds ? 64'd22 : 64'd20);
    case (id)
      3'd0: v = 0;
      3'd3: v = 64'd32768;
      3'd4: v = 64'd24000000;
      3'd5: v = 64'd3000000;
      3'd1, 3'd2: begin
        if (id == 3'd2 && s_persel) v = 64'd24000000;
        else begin
          if (s_psel) begin
            case (s_c2s)
              2'd0: v = 64'd480000000;
              2'd1: v = 64'd24000000;
              default: v = 0;
            endcase
            v = v / (64'(s_c2p) + 64'd1);
          end else begin
            case (s_pre)
              2'd0: v = sysp;
              2'd2: if (s_f0 == 0) e = 1; else v = sysp * 18 / 64'(s_f0);
              default: if (s_f2 == 0) e = 1; else v = sysp * 18 / 64'(s_f2);
            endcase
            if (s_pre == 2'd3) v = v / 2;
          end
          v = v / (64'(s_ahb) + 64'd1);
          v = v / (64'(s_ipg) + 64'd1);
        end
        if (id == 3'd2) v = v / (64'(s_perp) + 64'd1);
        if (e) v = 0;
      end
      default: begin e = 1; v = 0; end
    endcase
    return {e, v[31:0]};
  endfunction

  // run one request; disturb scrambles inputs and re-requests mid-flight (R12)
  task automatic run_req(input logic [2:0] id, input string tag, input bit disturb);
    logic [32:0] ex;
    int n;
    s_id = id;
    ex = model(id);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(busy_o == 1'b1, "R11 busy after accept", 64'(busy_o), 64'd1);
    if (disturb && !done_o) begin
      s_id = 3'd4; s_ds = ~s_ds; s_f0 = ~s_f0; s_f2 = ~s_f2; s_ahb = ~s_ahb;
      s_ipg = ~s_ipg; s_perp = ~s_perp; s_psel = ~s_psel; req = 1'b1;
      @(negedge clk); req = 1'b0;
    end
    n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) check(1'b0, {tag, " timeout"}, 64'(n), 64'd0);
    check(freq_o == ex[31:0], tag, 64'(freq_o), 64'(ex[31:0]));
    check(err_o == ex[32], {tag, " err"}, 64'(err_o), 64'(ex[32]));
    @(negedge clk);
    check(done_o == 1'b0, "R11 single done", 64'(done_o), 64'd0);
  endtask

  task automatic base_cfg();
    s_ds = 1; s_f0 = 6'd27; s_f2 = 6'd24; s_pre = 0; s_c2s = 0; s_c2p = 0;
    s_psel = 0; s_ahb = 0; s_ipg = 0; s_persel = 0; s_perp = 0;
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1357));
    req = 0; s_id = 0; base_cfg();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(done_o == 0 && busy_o == 0 && err_o == 0 && freq_o == 0, "R1 in reset", 64'(freq_o), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(done_o == 0 && busy_o == 0 && err_o == 0 && freq_o == 0, "R1 after release", 64'(freq_o), 64'd0);

    // R2 constant identifiers
    run_req(3'd0, "R2 none", 0);
    run_req(3'd3, "R2 low-freq", 0);
    run_req(3'd4, "R2 crystal", 0);
    run_req(3'd5, "R2 crystal/8", 0);
    // R3 system loop multiplier
    run_req(3'd1, "R3 x22", 0);
    s_ds = 0; run_req(3'd1, "R3 x20", 0);
    // R4 fractional dividers
    base_cfg(); s_pre = 1; run_req(3'd1, "R4 pfd2", 0);
    s_pre = 2; run_req(3'd1, "R4 pfd0", 0);
    s_pre = 3; run_req(3'd1, "R4 pfd2 half", 0);
    // R5 alternate path
    base_cfg(); s_psel = 1;
    s_c2s = 0; s_c2p = 3; run_req(3'd1, "R5 usb loop", 0);
    s_c2s = 1; s_c2p = 0; run_req(3'd1, "R5 crystal", 0);
    s_c2s = 2; run_req(3'd1, "R5 bypass zero", 0);
    s_c2s = 3; run_req(3'd1, "R5 reserved zero", 0);
    // R6 bus and IPG dividers
    base_cfg(); s_ahb = 3; s_ipg = 1; run_req(3'd1, "R6 bus/ipg", 0);
    // R7 peripheral path
    s_perp = 5; run_req(3'd2, "R7 from ipg", 0);
    s_persel = 1; s_perp = 63; run_req(3'd2, "R7 from crystal", 0);
    // R8 zero frac
    base_cfg(); s_pre = 1; s_f2 = 0; run_req(3'd1, "R8 zero frac used", 0);
    s_pre = 2; run_req(3'd1, "R8 zero frac unused", 0);
    // R9 unsupported identifiers
    run_req(3'd6, "R9 id6", 0);
    run_req(3'd7, "R9 id7", 0);
    // R10 truncation to 32 bits
    base_cfg(); s_pre = 1; s_f2 = 1; run_req(3'd1, "R10 truncate", 0);
    // R12 mid-flight changes ignored
    base_cfg(); s_pre = 3; s_ahb = 2; s_ipg = 2; s_perp = 7;
    run_req(3'd2, "R12 disturbed", 1);
    // R13 hold
    held = freq_o;
    repeat (6) @(negedge clk);
    check(freq_o == held && !done_o, "R13 hold", 64'(freq_o), 64'(held));

    // random mix
    for (int i = 0; i < 150; i++) begin
      s_ds = 1'($urandom); s_f0 = 6'($urandom); s_f2 = 6'($urandom);
      s_pre = 2'($urandom); s_c2s = 2'($urandom); s_c2p = 3'($urandom);
      s_psel = 1'($urandom); s_ahb = 3'($urandom); s_ipg = 2'($urandom);
      s_persel = 1'($urandom); s_perp = 6'($urandom);
      if (($urandom % 4) == 0) s_f2 = 0;
      run_req(3'($urandom), "R6 R7 R10 random", 0);
    end

    finished = 1;
    summary();
  end
endmodule